// File: doc/BRIEF.md
# Inhibitable Cycle Counter with Overflow Summary

This block is the cycle counter of a performance-monitoring unit. It keeps a 63-bit count of enabled clock cycles. A sticky overflow flag sits above the count, in bit 63 of the 64-bit value that software reads and writes. Software can stop the count with an inhibit bit and can reload it at any time through a simple write strobe.

When the count passes its all-ones value it wraps to zero. The wrap sets the overflow flag and bit 0 of a shared overflow summary. It also raises a one-cycle interrupt request, but only when the summary bit was clear before the wrap. The summary bit is cleared in two ways: a software write to the counter that leaves bit 63 at zero, or a dedicated clear input driven by the summary register owner.

The `tick_en` input qualifies each cycle. It lets the block count a divided or gated time base without a second clock.

Top module: `hpm_cycle_counter`

## Requirements
- R1: After reset the read value (flag and count) is 0, the summary bit is 0, the interrupt is 0 and the inhibit bit reads 1.
- R2: When `tick_en` is 1 and the registered inhibit bit is 0, the count increases by exactly 1 at that clock edge. When `tick_en` is 0, the count does not change.
- R3: While the inhibit bit is 1, the count holds its value, and the read value shows the held count together with the current flag in bit 63.
- R4: An increment from the all-ones count (2^63-1) gives a count of 0 after that edge, with bit 63 of the read value at 1 and the summary bit at 1.
- R5: A wrap drives `pmu_irq` high for exactly one cycle, in the same cycle the summary bit first reads 1. No pulse follows a wrap when the summary bit was already 1.
- R6: A counter write loads bits 62:0 of the write data as the count and bit 63 as the flag, visible after the edge. A write beats an increment in the same cycle.
- R7: A counter write with bit 63 at 0 clears the summary bit. A write with bit 63 at 1 leaves the summary bit unchanged.
- R8: A write to the inhibit bit takes effect from the following edge. The edge that captures the write is still governed by the old inhibit value, and clearing the inhibit resumes counting from the held count.
- R9: `ovf_sum_clr` clears the summary bit at the next edge. A wrap in the same cycle wins, and the summary bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Per-cycle count enable |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | 64 | Counter write value: bit 63 is the flag, bits 62:0 are the count |
| inh_wr_en | input | 1 | Inhibit bit write strobe |
| inh_wr_data | input | 1 | New inhibit bit value |
| cnt_rd_data | output | 64 | Flag in bit 63, count in bits 62:0 |
| inh_rd | output | 1 | Current inhibit bit |
| ovf_sum | output | 1 | Bit 0 of the shared overflow summary |
| ovf_sum_clr | input | 1 | Clears the summary bit |
| pmu_irq | output | 1 | One-cycle performance-monitor interrupt request |

## Verification
A wrong count or flag shows on `cnt_rd_data` one edge after the faulty update, because the read value is the state register with no staging. A wrong summary or interrupt decision shows on `ovf_sum` and `pmu_irq` in the first cycle after the wrap edge. A missed or repeated pulse is visible one cycle later. A wrong inhibit timing shows up as an off-by-one count on the cycle right after the inhibit write. The directed tests therefore sample at each of these edges. They do not sample only at the end of a scenario.

// File: rtl/hpm_cyc_pkg.sv
package hpm_cyc_pkg;

    // Source of the next count value, decided once per cycle.
    typedef enum logic [1:0] {
        CSRC_HOLD = 2'd0,
        CSRC_INC  = 2'd1,
        CSRC_LOAD = 2'd2
    } cnt_src_e;

endpackage

// File: rtl/hpm_cyc_ctl.sv
module hpm_cyc_ctl
    import hpm_cyc_pkg::*;
(
    input  logic     wr_en,
    input  logic     tick_en,
    input  logic     inh_q,
    input  logic     at_max,
    output cnt_src_e src,
    output logic     wrap
);

    always_comb begin
        if (wr_en) begin
            src = CSRC_LOAD;
        end else if (tick_en && !inh_q) begin
            src = CSRC_INC;
        end else begin
            src = CSRC_HOLD;
        end
        wrap = (src == CSRC_INC) && at_max;
    end

endmodule

// File: rtl/hpm_cyc_count.sv
module hpm_cyc_count
    import hpm_cyc_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_src_e         src,
    input  logic [CNT_W:0]   load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (src)
            CSRC_LOAD: begin
                st_d.cnt  = load_val[CNT_W-1:0];
                st_d.flag = load_val[CNT_W];
            end
            CSRC_INC: begin
                st_d.cnt = st_q.cnt + CNT_ONE;
                if (st_q.cnt == CNT_MAX) begin
                    st_d.flag = 1'b1;
                end
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign flag   = st_q.flag;
    assign at_max = (st_q.cnt == CNT_MAX);

endmodule

// File: rtl/hpm_cyc_ovf.sv
module hpm_cyc_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic wr_clr,
    input  logic ext_clr,
    output logic sum,
    output logic irq
);

    typedef struct packed {
        logic sum;
        logic irq;
    } ovf_state_t;

    ovf_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = wrap && !st_q.sum;
        if (wrap) begin
            st_d.sum = 1'b1;
        end else if (wr_clr || ext_clr) begin
            st_d.sum = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum = st_q.sum;
    assign irq = st_q.irq;

endmodule

// File: rtl/hpm_cycle_counter.sv
module hpm_cycle_counter
    import hpm_cyc_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_en,
    input  logic           cnt_wr_en,
    input  logic [CNT_W:0] cnt_wr_data,
    input  logic           inh_wr_en,
    input  logic           inh_wr_data,
    output logic [CNT_W:0] cnt_rd_data,
    output logic           inh_rd,
    output logic           ovf_sum,
    input  logic           ovf_sum_clr,
    output logic           pmu_irq
);

    localparam int FLAG_POS = CNT_W;

    logic inh_d, inh_q;

    always_comb begin
        inh_d = inh_q;
        if (inh_wr_en) begin
            inh_d = inh_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q <= 1'b1;
        end else begin
            inh_q <= inh_d;
        end
    end

    cnt_src_e         src;
    logic             wrap;
    logic             at_max;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             wr_clr;

    hpm_cyc_ctl u_ctl (
        .wr_en   (cnt_wr_en),
        .tick_en (tick_en),
        .inh_q   (inh_q),
        .at_max  (at_max),
        .src     (src),
        .wrap    (wrap)
    );

    hpm_cyc_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .load_val (cnt_wr_data),
        .cnt      (cnt),
        .flag     (flag),
        .at_max   (at_max)
    );

    assign wr_clr = cnt_wr_en && !cnt_wr_data[FLAG_POS];

    hpm_cyc_ovf u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .wr_clr  (wr_clr),
        .ext_clr (ovf_sum_clr),
        .sum     (ovf_sum),
        .irq     (pmu_irq)
    );

    assign cnt_rd_data = {flag, cnt};
    assign inh_rd      = inh_q;

endmodule

// File: rtl/hpm_cycle_counter_chk.sv
module hpm_cycle_counter_chk #(
    parameter int CNT_W = 63
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           cnt_wr_en,
    input logic [CNT_W:0] cnt_wr_data,
    input logic           inh_rd,
    input logic [CNT_W:0] cnt_rd_data,
    input logic           ovf_sum,
    input logic           pmu_irq
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic             adv;
    logic [CNT_W-1:0] cval;

    assign cval = cnt_rd_data[CNT_W-1:0];
    assign adv  = tick_en && !inh_rd && !cnt_wr_en;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cval != CMAX) |=> (cnt_rd_data[CNT_W-1:0] == $past(cval) + 1'b1));

    assert_inhibit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_rd && !cnt_wr_en) |=> $stable(cnt_rd_data));

    assert_wrap_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cval == CMAX) |=> (cnt_rd_data[CNT_W-1:0] == '0 && cnt_rd_data[CNT_W] && ovf_sum));

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pmu_irq |=> !pmu_irq);

    assert_irq_with_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pmu_irq |-> ovf_sum);

    assert_write_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_en |=> (cnt_rd_data == $past(cnt_wr_data)));

    assert_write_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_en && !cnt_wr_data[CNT_W]) |=> !ovf_sum);

endmodule

bind hpm_cycle_counter hpm_cycle_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .inh_rd      (inh_rd),
    .cnt_rd_data (cnt_rd_data),
    .ovf_sum     (ovf_sum),
    .pmu_irq     (pmu_irq)
);

// File: tb/tb_hpm_cycle_counter.sv
module tb_hpm_cycle_counter;

    localparam int CNT_W = 63;
    localparam int REG_W = CNT_W + 1;
    localparam logic [REG_W-1:0] FLAG = {1'b1, {CNT_W{1'b0}}};
    localparam logic [REG_W-1:0] CMAX = {1'b0, {CNT_W{1'b1}}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             cnt_wr_en = 1'b0;
    logic [REG_W-1:0] cnt_wr_data = '0;
    logic             inh_wr_en = 1'b0;
    logic             inh_wr_data = 1'b0;
    logic [REG_W-1:0] cnt_rd_data;
    logic             inh_rd;
    logic             ovf_sum;
    logic             ovf_sum_clr = 1'b0;
    logic             pmu_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hpm_cycle_counter #(.CNT_W(CNT_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cnt_wr_en   (cnt_wr_en),
        .cnt_wr_data (cnt_wr_data),
        .inh_wr_en   (inh_wr_en),
        .inh_wr_data (inh_wr_data),
        .cnt_rd_data (cnt_rd_data),
        .inh_rd      (inh_rd),
        .ovf_sum     (ovf_sum),
        .ovf_sum_clr (ovf_sum_clr),
        .pmu_irq     (pmu_irq)
    );

    task automatic check(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_cnt(input logic [REG_W-1:0] v);
        cnt_wr_en = 1'b1;
        cnt_wr_data = v;
        step();
        cnt_wr_en = 1'b0;
    endtask

    task automatic wr_inh(input logic v);
        inh_wr_en = 1'b1;
        inh_wr_data = v;
        step();
        inh_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", cnt_rd_data, '0);
        check("R1 inhibit", REG_W'(inh_rd), 1);
        check("R1 summary", REG_W'(ovf_sum), 0);
        check("R1 irq", REG_W'(pmu_irq), 0);
    endtask

    task automatic t_inhibit_hold();
        tick_en = 1'b1;
        repeat (5) step();
        check("R3 held at zero", cnt_rd_data, '0);
        wr_cnt(FLAG | 64'h55);
        repeat (4) step();
        check("R3 held with flag", cnt_rd_data, FLAG | 64'h55);
        wr_cnt(64'h0);
    endtask

    task automatic t_count();
        wr_inh(1'b0);
        check("R8 old inhibit governs capture edge", cnt_rd_data, 64'h0);
        check("R8 inhibit reads 0", REG_W'(inh_rd), 0);
        repeat (4) step();
        check("R2 four increments", cnt_rd_data, 64'h4);
        tick_en = 1'b0;
        repeat (3) step();
        check("R2 no tick no change", cnt_rd_data, 64'h4);
        for (int i = 0; i < 6; i++) begin
            tick_en = (i % 2) == 0;
            step();
        end
        check("R2 alternating tick", cnt_rd_data, 64'h7);
        tick_en = 1'b1;
    endtask

    task automatic t_write_priority();
        wr_cnt(64'h1234);
        check("R6 write beats increment", cnt_rd_data, 64'h1234);
        step();
        check("R2 counts after load", cnt_rd_data, 64'h1235);
    endtask

    task automatic t_inhibit_resume();
        wr_inh(1'b1);
        check("R8 increment on capture edge", cnt_rd_data, 64'h1236);
        repeat (3) step();
        check("R3 frozen while inhibited", cnt_rd_data, 64'h1236);
        wr_inh(1'b0);
        check("R8 still frozen on clearing edge", cnt_rd_data, 64'h1236);
        step();
        check("R8 resumes from held value", cnt_rd_data, 64'h1237);
    endtask

    task automatic t_wrap_first();
        wr_cnt(CMAX - 1);
        check("R6 load near max", cnt_rd_data, CMAX - 1);
        step();
        check("R2 reaches max", cnt_rd_data, CMAX);
        check("R5 no irq before wrap", REG_W'(pmu_irq), 0);
        step();
        check("R4 wrap count and flag", cnt_rd_data, FLAG);
        check("R4 summary set", REG_W'(ovf_sum), 1);
        check("R5 irq on first wrap", REG_W'(pmu_irq), 1);
        step();
        check("R5 irq one cycle", REG_W'(pmu_irq), 0);
        check("R4 flag sticky", cnt_rd_data, FLAG | 64'h1);
    endtask

    task automatic t_wrap_second();
        wr_cnt(FLAG | CMAX);
        check("R7 flag-set write keeps summary", REG_W'(ovf_sum), 1);
        step();
        check("R4 second wrap", cnt_rd_data, FLAG);
        check("R5 no irq while summary set", REG_W'(pmu_irq), 0);
        check("R4 summary stays", REG_W'(ovf_sum), 1);
        wr_cnt(64'h10);
        check("R7 flag-clear write clears summary", REG_W'(ovf_sum), 0);
        check("R6 write clears flag", cnt_rd_data, 64'h10);
    endtask

    task automatic t_ext_clear();
        wr_cnt(CMAX);
        step();
        check("R4 wrap again", REG_W'(ovf_sum), 1);
        check("R5 irq after re-arm", REG_W'(pmu_irq), 1);
        ovf_sum_clr = 1'b1;
        step();
        ovf_sum_clr = 1'b0;
        check("R9 clear input", REG_W'(ovf_sum), 0);
        wr_cnt(FLAG | CMAX);
        check("R7 summary unchanged by flag write", REG_W'(ovf_sum), 0);
        ovf_sum_clr = 1'b1;
        step();
        ovf_sum_clr = 1'b0;
        check("R9 wrap beats clear", REG_W'(ovf_sum), 1);
        check("R5 irq when summary was clear", REG_W'(pmu_irq), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_inhibit_hold();
        t_count();
        t_write_priority();
        t_inhibit_resume();
        t_wrap_first();
        t_wrap_second();
        t_ext_clear();
        finish_run();
    end

endmodule